// File: doc/BRIEF.md
# Speculative Two-Threshold Decision-Feedback Slicer

This block is the digital decision stage of a receiver for a two-level serial stream. Each bit time it takes one digitised sample, a signed fixed-point value, and decides whether the transmitted symbol was +1 or -1. The channel adds interference from the previous symbol. That interference is a first post-cursor term of size alpha, so an ideal received sample takes one of four values: ±1±alpha.

The block does not subtract a feedback term from the sample before it decides. It compares every sample against two thresholds at the same time. One threshold, +alpha, is correct when the previous decision was 1. The other, -alpha, is correct when the previous decision was 0. Only the previous decision, already held in a register, chooses between the two comparison results. The only logic in the loop from one decision to the next is therefore a 2:1 selector. The comparators sit outside that loop and have the whole bit time to settle.

A small controller has two states. `ST_IDLE` means no sample was taken on the last clock. `ST_STREAM` means a sample was taken on the last clock. The transition `T_START` (ST_IDLE to ST_STREAM) fires when `in_valid` is high. `T_GAP` (ST_STREAM to ST_IDLE) fires when `in_valid` is low. `T_HOLD_IDLE` keeps the state in ST_IDLE while `in_valid` stays low, and `T_HOLD_STREAM` keeps it in ST_STREAM while `in_valid` stays high. `out_valid` is high exactly in ST_STREAM. The tap value `tap_alpha` may only be changed while the block is in reset or in ST_IDLE.

Top module: `spec_dfe_slicer`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `out_valid` is 0 and `out_bit` is 0. The stored previous decision starts at 0, so the first sample is sliced against -alpha.
- R2: `out_valid` is high in the cycle right after a clock edge where `in_valid` was high, and low after an edge where `in_valid` was low.
- R3: When the stored previous decision is 1, an accepted sample produces `out_bit` = 1 exactly when the sample, read as 8-bit two's complement, is greater than or equal to +`tap_alpha`, read as 8-bit unsigned.
- R4: When the stored previous decision is 0, an accepted sample produces `out_bit` = 1 exactly when the sample is greater than or equal to -`tap_alpha`.
- R5: A sample exactly equal to the selected threshold is decided as 1.
- R6: A clock edge with `in_valid` low leaves `out_bit` unchanged, and with it the stored previous decision. The first sample after a gap is therefore sliced using the decision made before the gap.
- R7: The comparison never wraps. With `tap_alpha` = 255 every 8-bit sample decides 0 after a previous 1, and decides 1 after a previous 0. With `tap_alpha` = 0 the block acts as a plain sign slicer: sample >= 0 gives 1.
- R8: `tap_alpha` stays unchanged on any edge where both `in_valid` and `out_valid` are high. This is a condition the user must meet, and it is checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_sample | input | 8 | Received sample, two's complement |
| tap_alpha | input | 8 | First post-cursor tap magnitude, unsigned |
| out_valid | output | 1 | `out_bit` holds a new decision |
| out_bit | output | 1 | Decided symbol (1 = +1, 0 = -1); also the stored previous decision |

## Verification
The checker verifies the following on every clock edge:
- the one-cycle relation between `in_valid` and `out_valid`;
- the choice of threshold for both values of the previous decision;
- that `out_bit` holds across gaps;
- that the tap stays stable during streaming.

Some behaviour only the bench's scenarios can show:
- the reset value and the first decision after reset;
- decisions that land exactly on a threshold;
- the extreme tap values at both ends of the sample range;
- a history that carries across multi-cycle gaps.

The bench's behavioural model compares both outputs on every cycle.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
    localparam int SAMPLE_W = 8;
    localparam int TAP_W    = 8;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } dfe_state_e;
endpackage

// File: rtl/dfe_thresh_cmp.sv
// One speculative slicer: sample >= (+alpha or -alpha), with no wrap.
module dfe_thresh_cmp #(
    parameter int SW      = 8,
    parameter int AW      = 8,
    parameter bit NEG_THR = 1'b0
) (
    input  logic [SW-1:0] sample,
    input  logic [AW-1:0] alpha,
    output logic          ge
);
    localparam int CW = ((SW > AW + 1) ? SW : AW + 1) + 1;

    logic signed [CW-1:0] s_ext;
    logic signed [CW-1:0] a_ext;
    logic signed [CW-1:0] thr;

    always_comb begin
        s_ext = {{(CW-SW){sample[SW-1]}}, sample};
        a_ext = {{(CW-AW){1'b0}}, alpha};
        thr   = NEG_THR ? -a_ext : a_ext;
        ge    = (s_ext >= thr);
    end
endmodule

// File: rtl/dfe_decision_reg.sv
// Feedback loop: only a 2:1 select between pre-computed results.
module dfe_decision_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic ge_after_one,
    input  logic ge_after_zero,
    output logic d_q
);
    logic d_next;

    always_comb begin
        d_next = d_q ? ge_after_one : ge_after_zero;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q <= 1'b0;
        end else if (take) begin
            d_q <= d_next;
        end
    end
endmodule

// File: rtl/spec_dfe_slicer.sv
module spec_dfe_slicer
    import dfe_pkg::*;
#(
    parameter int SW = SAMPLE_W,
    parameter int AW = TAP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [SW-1:0] in_sample,
    input  logic [AW-1:0] tap_alpha,
    output logic          out_valid,
    output logic          out_bit
);
    localparam int N_SPEC = 2;   // index 0: prev was 0, index 1: prev was 1

    dfe_state_e state_q;
    dfe_state_e state_d;
    logic [N_SPEC-1:0] spec_ge;
    logic              dec_q;

    // Speculative comparators, one per possible previous decision
    for (genvar gi = 0; gi < N_SPEC; gi++) begin : g_spec
        dfe_thresh_cmp #(
            .SW      (SW),
            .AW      (AW),
            .NEG_THR (gi == 0)
        ) u_cmp (
            .sample (in_sample),
            .alpha  (tap_alpha),
            .ge     (spec_ge[gi])
        );
    end

    dfe_decision_reg u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .take          (in_valid),
        .ge_after_one  (spec_ge[1]),
        .ge_after_zero (spec_ge[0]),
        .d_q           (dec_q)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_STREAM : ST_IDLE;    // T_START / T_HOLD_IDLE
            ST_STREAM: state_d = in_valid ? ST_STREAM : ST_IDLE;    // T_HOLD_STREAM / T_GAP
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   out_valid = 1'b0;
            ST_STREAM: out_valid = 1'b1;
            default:   out_valid = 1'b0;
        endcase
        out_bit = dec_q;
    end
endmodule

// File: rtl/dfe_slicer_chk.sv
module dfe_slicer_chk #(
    parameter int SW = 8,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [SW-1:0] in_sample,
    input logic [AW-1:0] tap_alpha,
    input logic          out_valid,
    input logic          out_bit
);
    localparam int CW = ((SW > AW + 1) ? SW : AW + 1) + 1;

    logic signed [CW-1:0] c_s;
    logic signed [CW-1:0] c_a;
    logic                 c_hi_ok;
    logic                 c_lo_ok;

    always_comb begin
        c_s     = {{(CW-SW){in_sample[SW-1]}}, in_sample};
        c_a     = {{(CW-AW){1'b0}}, tap_alpha};
        c_hi_ok = (c_s >= c_a);
        c_lo_ok = (c_s + c_a >= 0);
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_PREV_ONE_THR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_bit) |=> (out_bit == $past(c_hi_ok))); // R3
    AST_PREV_ZERO_THR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !out_bit) |=> (out_bit == $past(c_lo_ok))); // R4
    AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_bit)); // R6
    AST_TAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_valid) |-> $stable(tap_alpha)); // R8
endmodule

bind spec_dfe_slicer dfe_slicer_chk #(.SW(SW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .tap_alpha (tap_alpha),
    .out_valid (out_valid),
    .out_bit   (out_bit)
);

// File: tb/spec_dfe_slicer_tb.sv
`timescale 1ns/1ps
module spec_dfe_slicer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_sample = 8'd0;
    logic [7:0] tap_alpha = 8'd0;
    logic       out_valid;
    logic       out_bit;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference model state
    int    m_prev   = 0;
    bit    exp_valid = 1'b0;
    bit    exp_bit   = 1'b0;
    string exp_tag   = "R1";

    always #4 clk = ~clk;   // 125 MHz

    spec_dfe_slicer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .tap_alpha (tap_alpha),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare the outputs for the previous step, then drive this step and update the model
    task automatic step(input bit v, input int s);
        int thr;
        @(negedge clk);
        check(out_valid == exp_valid, exp_valid ? "R2" : (exp_tag == "R1" ? "R1" : "R2"),
              out_valid, exp_valid);
        check(out_bit == exp_bit, exp_tag, out_bit, exp_bit);
        in_valid  = v;
        in_sample = 8'(s);
        exp_valid = v;
        if (v) begin
            thr     = (m_prev != 0) ? int'(tap_alpha) : -int'(tap_alpha);
            exp_bit = (s >= thr);
            if (tap_alpha == 8'd255 || tap_alpha == 8'd0) exp_tag = "R7";
            else if (s == thr)                            exp_tag = "R5";
            else if (m_prev != 0)                         exp_tag = "R3";
            else                                          exp_tag = "R4";
            m_prev = exp_bit ? 1 : 0;
        end else begin
            exp_tag = "R6";
        end
    endtask

    // R8: the tap changes only after an idle cycle
    task automatic set_tap(input int a);
        step(1'b0, 0);
        tap_alpha = 8'(a);
    endtask

    initial begin
        tap_alpha = 8'd20;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(out_bit == 1'b0, "R1", out_bit, 0);
        rst_n = 1'b1;
        // R1/R5: first sample after reset uses -alpha, and equality decides 1
        step(1'b1, -20);
        step(1'b1, 20);      // previous 1, equal to +alpha: R5
        step(1'b1, 19);      // previous 1, just below: R3 -> 0
        step(1'b1, -21);     // previous 0, just below -alpha: R4 -> 0
        step(1'b1, -19);     // previous 0: R4 -> 1
        // R6: gap that holds the history
        step(1'b0, 127);
        step(1'b0, -128);
        step(1'b0, 5);
        step(1'b1, 10);      // uses previous 1: 10 < 20 -> 0
        // Mixed stream, alpha 20
        for (int i = 0; i < 80; i++) begin
            step((i % 7) != 3, ((i * 37 + 11) % 256) - 128);
        end
        // R7: zero tap acts as a sign slicer
        set_tap(0);
        step(1'b1, 0);
        step(1'b1, -1);
        step(1'b1, 0);
        step(1'b1, 1);
        // R7: maximum tap, extremes of the sample range
        set_tap(255);
        step(1'b1, 127);     // prev 1 -> 0
        step(1'b1, -128);    // prev 0 -> 1
        step(1'b1, 127);     // prev 1 -> 0
        step(1'b1, -128);
        // Mid tap with exact thresholds, including across a gap
        set_tap(100);
        step(1'b1, -100);
        step(1'b1, 100);
        step(1'b0, 0);
        step(1'b1, 99);
        step(1'b1, -100);
        for (int i = 0; i < 60; i++) begin
            step((i % 5) != 0, ((i * 91 + 3) % 256) - 128);
        end
        step(1'b0, 0);
        step(1'b0, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule